// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits between a simple host request port and an asynchronous 8-bit NAND flash bus. Each accepted request is one bus operation: a command byte, a full address, a written data byte or a read data byte. The sequencer selects the device and sets the latch-enable levels that belong to that operation. It then produces the write or read strobe for as many bytes as the operation needs, and returns the device to standby when it has finished. Strobe low and high times are elaboration-time counts of system clocks, so one netlist can be tuned to the flash part's timing and the system clock frequency.

An address request carries the whole address in one word. The sequencer emits it one byte per write strobe, least significant byte first. A configuration input picks four or five address bytes, which covers both smaller and larger densities. Read data is sampled in the last clock before the read strobe rises and is handed back through a valid/ready pair. Every request carries a modify flag. The write-protect output follows this flag and holds its value between requests, so that a program or erase sequence made of several requests stays unprotected throughout.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset and whenever busy is low, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale and nand_io_oe are 0, and nand_wp_n is 0 straight after reset.
- R2: A command request (req_op 0) makes exactly one write-strobe pulse, with nand_ce_n 0, nand_cle 1, nand_ale 0, nand_re_n 1 and nand_io_out equal to req_byte while the strobe is low.
- R3: An address request (req_op 1) makes 5 write-strobe pulses when cfg_five_addr is 1 and 4 when it is 0. Each pulse has nand_ale 1 and nand_cle 0, and pulse k carries req_addr[8k+7:8k], starting at k = 0.
- R4: A data-write request (req_op 2) makes exactly one write-strobe pulse, with nand_cle and nand_ale 0 and nand_io_out equal to req_byte.
- R5: A read request (req_op 3) makes one read-strobe pulse and no write-strobe pulse, with nand_cle and nand_ale 0. It returns the nand_io_in value present in the last clock of the low phase on rd_data, with rd_valid held high and rd_data held unchanged until rd_ready is high.
- R6: The write strobe stays low for exactly WE_LO clocks and the read strobe for exactly RE_LO clocks.
- R7: nand_wp_n takes the req_modify value of each accepted request and keeps it until the next request is accepted.
- R8: req_ready is high only when the sequencer is idle and no read byte is waiting. busy is high for exactly (bytes × (low+high count)) clocks, starting the clock after acceptance.
- R9: nand_io_oe is high during command, address and data-write operations and low throughout a read.
- R10: nand_cle and nand_ale are never both high, and nand_we_n and nand_re_n are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_modify | input | 1 | Request belongs to a program or erase sequence |
| req_addr | input | IO_W*ADDR_CYC_MAX | Full address, low byte sent first |
| req_byte | input | IO_W | Command code or write data |
| cfg_five_addr | input | 1 | 1 selects five address bytes, 0 selects four |
| busy | output | 1 | Bus operation in progress |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | IO_W | Captured read byte |
| nand_ce_n | output | 1 | Device select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_io_out | output | IO_W | Byte driven onto the flash bus |
| nand_io_oe | output | 1 | Output enable for the bus driver |
| nand_io_in | input | IO_W | Byte sampled from the flash bus |

## Verification
The bound checker watches, on every clock, the standby pin levels when idle, the mutual exclusion of the latch enables and of the two strobes, the release of the bus driver whenever the read strobe is low, and the exact low widths of both strobes. It also checks that a waiting read byte stays put, that the ready condition holds, and that write protect cannot change between requests. The order and values of the address bytes, the choice between four and five bytes, the latch-enable levels seen with each byte, the busy window length and the sampling of read data are shown only by the bench's scenarios. Those scenarios record every strobe pulse at the pins and compare it with the request that was issued.

// File: rtl/nbs_pkg.sv
// Shared types for the NAND bus sequencer.
// Assumes: four operation kinds, encoded as the req_op port values.
package nbs_pkg;

    typedef enum logic [1:0] {
        NOP_CMD  = 2'd0,
        NOP_ADDR = 2'd1,
        NOP_WR   = 2'd2,
        NOP_RD   = 2'd3
    } nbs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } nbs_state_e;

    typedef struct packed {
        logic ce_n;
        logic cle;
        logic ale;
        logic we_n;
        logic re_n;
        logic io_oe;
    } nbs_pins_t;

endpackage

// File: rtl/nbs_phase_ctr.sv
// Phase length counter: counts clocks within the current strobe phase and
// flags the last clock of it. Assumes limit >= 1 while run is high.
module nbs_phase_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q == limit - 1'b1);

    // Count up inside a phase; restart at each phase boundary or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/nbs_pin_map.sv
// Pin level decode: maps sequencer state and operation kind to the flash
// control pin levels. Purely combinational; assumes registered inputs.
module nbs_pin_map
    import nbs_pkg::*;
(
    input  nbs_state_e state,
    input  nbs_op_e    op,
    output nbs_pins_t  pins
);
    // Standby when idle; otherwise select the device and strobe in the low phase.
    always_comb begin
        pins = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0, we_n: 1'b1, re_n: 1'b1, io_oe: 1'b0};
        if (state != ST_IDLE) begin
            pins.ce_n  = 1'b0;
            pins.cle   = (op == NOP_CMD);
            pins.ale   = (op == NOP_ADDR);
            pins.io_oe = (op != NOP_RD);
            if (state == ST_LOW) begin
                if (op == NOP_RD)
                    pins.re_n = 1'b0;
                else
                    pins.we_n = 1'b0;
            end
        end
    end
endmodule

// File: rtl/nbs_rd_buf.sv
// Read byte holder: captures one byte and offers it on valid/ready.
// Assumes capture is never raised while a byte is still waiting.
module nbs_rd_buf #(
    parameter int IO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [IO_W-1:0] din,
    input  logic            rd_ready,
    output logic            rd_valid,
    output logic [IO_W-1:0] rd_data
);
    // Load on capture, drop valid once the host takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (capture) begin
            rd_valid <= 1'b1;
            rd_data  <= din;
        end else if (rd_valid && rd_ready) begin
            rd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nand_bus_seq.sv
// NAND bus sequencer top: accepts one request at a time and plays it out as
// strobe cycles on an asynchronous NAND bus. Assumes all timing counts >= 1,
// ADDR_CYC_MAX >= 2, and nand_io_in stable in the last clock of read-low.
module nand_bus_seq
    import nbs_pkg::*;
#(
    parameter int IO_W         = 8,
    parameter int ADDR_CYC_MAX = 5,
    parameter int WE_LO        = 2,
    parameter int WE_HI        = 3,
    parameter int RE_LO        = 3,
    parameter int RE_HI        = 2,
    localparam int ADDR_W      = IO_W * ADDR_CYC_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic              req_modify,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IO_W-1:0]   req_byte,
    input  logic              cfg_five_addr,
    output logic              busy,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [IO_W-1:0]   rd_data,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic [IO_W-1:0]   nand_io_out,
    output logic              nand_io_oe,
    input  logic [IO_W-1:0]   nand_io_in
);
    localparam int T_MAX_W = (WE_LO > WE_HI) ? WE_LO : WE_HI;
    localparam int T_MAX_R = (RE_LO > RE_HI) ? RE_LO : RE_HI;
    localparam int T_MAX   = (T_MAX_W > T_MAX_R) ? T_MAX_W : T_MAX_R;
    localparam int CNT_W   = $clog2(T_MAX + 1);
    localparam int BC_W    = $clog2(ADDR_CYC_MAX + 1);

    nbs_state_e        state_q;
    nbs_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IO_W-1:0]   byte_q;
    logic [BC_W-1:0]   left_q;
    logic              wp_q;
    logic              acc;
    logic              last;
    logic              is_rd;
    logic [CNT_W-1:0]  lim;
    nbs_pins_t         pins;

    assign req_ready = (state_q == ST_IDLE) && !rd_valid;
    assign acc       = req_valid && req_ready;
    assign is_rd     = (op_q == NOP_RD);
    assign busy      = (state_q != ST_IDLE);

    // Pick the length of the current phase from the strobe in use.
    always_comb begin
        if (state_q == ST_LOW)
            lim = is_rd ? CNT_W'(RE_LO) : CNT_W'(WE_LO);
        else
            lim = is_rd ? CNT_W'(RE_HI) : CNT_W'(WE_HI);
    end

    nbs_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .limit (lim),
        .last  (last)
    );

    // Operation sequencing: latch the request, alternate low/high phases per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= NOP_CMD;
            addr_q  <= '0;
            byte_q  <= '0;
            left_q  <= '0;
            wp_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (acc) begin
                        state_q <= ST_LOW;
                        op_q    <= nbs_op_e'(req_op);
                        addr_q  <= req_addr;
                        byte_q  <= req_byte;
                        wp_q    <= req_modify;
                        if (nbs_op_e'(req_op) == NOP_ADDR)
                            left_q <= cfg_five_addr ? BC_W'(ADDR_CYC_MAX - 1)
                                                    : BC_W'(ADDR_CYC_MAX - 2);
                        else
                            left_q <= '0;
                    end
                end
                ST_LOW: begin
                    if (last)
                        state_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (last) begin
                        if (left_q == '0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_LOW;
                            left_q  <= left_q - 1'b1;
                            addr_q  <= addr_q >> IO_W;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    nbs_pin_map u_pins (
        .state (state_q),
        .op    (op_q),
        .pins  (pins)
    );

    nbs_rd_buf #(.IO_W(IO_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  ((state_q == ST_LOW) && last && is_rd),
        .din      (nand_io_in),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign nand_ce_n   = pins.ce_n;
    assign nand_cle    = pins.cle;
    assign nand_ale    = pins.ale;
    assign nand_we_n   = pins.we_n;
    assign nand_re_n   = pins.re_n;
    assign nand_io_oe  = pins.io_oe;
    assign nand_wp_n   = wp_q;
    assign nand_io_out = pins.io_oe ? ((op_q == NOP_ADDR) ? addr_q[IO_W-1:0] : byte_q) : '0;
endmodule

// File: rtl/nbs_chk.sv
// Protocol checker for the NAND bus sequencer, bound to the top module.
// Assumes reset is applied in the first cycles of the run.
module nbs_chk #(
    parameter int IO_W  = 8,
    parameter int WE_LO = 2,
    parameter int RE_LO = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [IO_W-1:0] rd_data,
    input logic            nand_ce_n,
    input logic            nand_cle,
    input logic            nand_ale,
    input logic            nand_we_n,
    input logic            nand_re_n,
    input logic            nand_wp_n,
    input logic            nand_io_oe
);
    logic [15:0] we_lo_cnt;
    logic [15:0] re_lo_cnt;

    // Measure the current low stretch of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            re_lo_cnt <= '0;
        end else begin
            we_lo_cnt <= nand_we_n ? 16'd0 : we_lo_cnt + 16'd1;
            re_lo_cnt <= nand_re_n ? 16'd0 : re_lo_cnt + 16'd1;
        end
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe));

    // R10
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_we_n || nand_re_n);

    // R9
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

    // R6
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_we_n && !$past(nand_we_n)) |-> (we_lo_cnt == 16'(WE_LO)));

    // R6
    re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_re_n && !$past(nand_re_n)) |-> (re_lo_cnt == 16'(RE_LO)));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R8
    ready_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!busy && !rd_valid));

    // R7
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(req_valid && req_ready)) |-> $stable(nand_wp_n));
endmodule

bind nand_bus_seq nbs_chk #(.IO_W(IO_W), .WE_LO(WE_LO), .RE_LO(RE_LO)) u_nbs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_wp_n  (nand_wp_n),
    .nand_io_oe (nand_io_oe)
);

// File: tb/nand_bus_seq_test.sv
// Bench for the NAND bus sequencer: a vector table walked by one loop, then
// directed tests for reset, write-protect hold and read back-pressure.
module nand_bus_seq_test;
    localparam int WL = 2;
    localparam int WH = 3;
    localparam int RL = 3;
    localparam int RH = 2;

    // Vector layout: [43:42] op, [41] modify, [40] five-byte address, [39:0] value.
    localparam logic [43:0] VEC [0:7] = '{
        {2'd0, 1'b1, 1'b0, 40'h00_0000_0080},
        {2'd1, 1'b1, 1'b0, 40'h00_0403_0201},
        {2'd2, 1'b1, 1'b0, 40'h00_0000_005A},
        {2'd0, 1'b1, 1'b0, 40'h00_0000_0010},
        {2'd1, 1'b0, 1'b1, 40'hA5_C33C_F00F},
        {2'd3, 1'b0, 1'b0, 40'h00_0000_0096},
        {2'd1, 1'b0, 1'b0, 40'hFF_EEDD_CCBB},
        {2'd3, 1'b0, 1'b0, 40'h00_0000_003C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic        req_modify = 1'b0;
    logic [39:0] req_addr = '0;
    logic [7:0]  req_byte = '0;
    logic        cfg_five_addr = 1'b0;
    logic        busy;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = '0;

    int tests = 0;
    int fails = 0;

    // Pin monitor state, cleared by the request task.
    int         we_pulses, re_pulses, busy_cyc, we_lo, re_lo, rd_got;
    logic [7:0] lb [0:7];
    logic       lcle [0:7];
    logic       lale [0:7];
    logic       lwp  [0:7];
    logic [7:0] cur_b;
    logic       cur_cle, cur_ale, cur_wp;
    logic       ce_bad, oe_rd_bad, rd_pin_bad, width_bad;
    logic       prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] rd_byte;

    // Loop and expectation variables.
    logic [43:0] v;
    int          nb, exp_busy;
    logic [7:0]  eb;

    nand_bus_seq #(.IO_W(8), .ADDR_CYC_MAX(5), .WE_LO(WL), .WE_HI(WH), .RE_LO(RL), .RE_HI(RH)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_modify(req_modify), .req_addr(req_addr), .req_byte(req_byte),
        .cfg_five_addr(cfg_five_addr), .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in)
    );

    always #10 clk = ~clk;

    // Record strobe pulses and handshakes at the falling edge, away from updates.
    always @(negedge clk) begin
        if (busy) busy_cyc = busy_cyc + 1;
        if (!nand_we_n) begin
            we_lo   = we_lo + 1;
            cur_b   = nand_io_out;
            cur_cle = nand_cle;
            cur_ale = nand_ale;
            cur_wp  = nand_wp_n;
            if (nand_ce_n || !nand_re_n || !nand_io_oe) ce_bad = 1'b1;
        end
        if (!prev_we && nand_we_n) begin
            if (we_pulses < 8) begin
                lb[we_pulses]   = cur_b;
                lcle[we_pulses] = cur_cle;
                lale[we_pulses] = cur_ale;
                lwp[we_pulses]  = cur_wp;
            end
            if (we_lo != WL) width_bad = 1'b1;
            we_pulses = we_pulses + 1;
            we_lo = 0;
        end
        if (!nand_re_n) begin
            re_lo = re_lo + 1;
            if (nand_io_oe) oe_rd_bad = 1'b1;
            if (nand_cle || nand_ale || nand_ce_n || !nand_we_n) rd_pin_bad = 1'b1;
        end
        if (!prev_re && nand_re_n) begin
            if (re_lo != RL) width_bad = 1'b1;
            re_pulses = re_pulses + 1;
            re_lo = 0;
        end
        if (rd_valid && rd_ready) begin
            rd_got  = rd_got + 1;
            rd_byte = rd_data;
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        we_pulses = 0; re_pulses = 0; busy_cyc = 0; we_lo = 0; re_lo = 0; rd_got = 0;
        ce_bad = 1'b0; oe_rd_bad = 1'b0; rd_pin_bad = 1'b0; width_bad = 1'b0;
        rd_byte = '0;
    endtask

    // Issue one request and wait until the bus operation has completed.
    task automatic do_req(input logic [1:0] op, input logic mod, input logic five, input logic [39:0] val);
        @(negedge clk);
        clear_mon();
        req_op = op; req_modify = mod; cfg_five_addr = five;
        req_addr = val; req_byte = val[7:0];
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        // R1: reset state of every control pin
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe && !busy,
            "R1 idle pins in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, busy}, 7'b1110000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!nand_wp_n, "R1 write protect after reset", nand_wp_n, 0);
        chk(req_ready && !rd_valid, "R8 ready after reset", {req_ready, rd_valid}, 2'b10);

        // Table walk: each row is one request, checked byte by byte at the pins.
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            nand_io_in = v[7:0];
            do_req(v[43:42], v[41], v[40], v[39:0]);
            nb = (v[43:42] == 2'd1) ? (v[40] ? 5 : 4) : ((v[43:42] == 2'd3) ? 0 : 1);
            exp_busy = (v[43:42] == 2'd3) ? (RL + RH) : nb * (WL + WH);
            chk(we_pulses == nb, "R3 write pulse count (R2 R4 R5)", we_pulses, nb);
            for (int k = 0; k < 5; k++) begin
                if (k < nb) begin
                    eb = (v[43:42] == 2'd1) ? v[8*k +: 8] : v[7:0];
                    chk(lb[k] == eb, "R3 byte on bus (R2 R4)", lb[k], eb);
                    chk(lcle[k] == (v[43:42] == 2'd0) && lale[k] == (v[43:42] == 2'd1),
                        "R2 latch enables per byte (R3 R4)", {lcle[k], lale[k]},
                        {v[43:42] == 2'd0, v[43:42] == 2'd1});
                    chk(lwp[k] == v[41], "R7 write protect during strobe", lwp[k], v[41]);
                end
            end
            chk(!ce_bad, "R9 select and driver during write strobe", ce_bad, 0);
            chk(busy_cyc == exp_busy, "R8 busy window length", busy_cyc, exp_busy);
            chk(!width_bad, "R6 strobe low widths", width_bad, 0);
            chk(nand_wp_n == v[41], "R7 write protect held after request", nand_wp_n, v[41]);
            if (v[43:42] == 2'd3) begin
                chk(re_pulses == 1, "R5 one read pulse", re_pulses, 1);
                chk(!oe_rd_bad, "R9 driver released during read", oe_rd_bad, 0);
                chk(!rd_pin_bad, "R5 pin levels during read", rd_pin_bad, 0);
                chk(rd_got == 1 && rd_byte == v[7:0], "R5 read data returned", rd_byte, v[7:0]);
            end else begin
                chk(re_pulses == 0, "R5 no read pulse on write ops", re_pulses, 0);
            end
            chk(nand_ce_n && !nand_io_oe, "R1 standby after op", {nand_ce_n, nand_io_oe}, 2'b10);
        end

        // R7: protect released by a modify request stays released while idle.
        do_req(2'd0, 1'b1, 1'b0, 40'h60);
        repeat (4) @(negedge clk);
        chk(nand_wp_n, "R7 write protect held high while idle", nand_wp_n, 1);
        do_req(2'd0, 1'b0, 1'b0, 40'h70);
        chk(!nand_wp_n, "R7 write protect restored by plain request", nand_wp_n, 0);

        // R5/R8: a read byte waits for the host and blocks new requests.
        rd_ready = 1'b0;
        nand_io_in = 8'hE7;
        do_req(2'd3, 1'b0, 1'b0, 40'h0);
        nand_io_in = 8'h00;
        chk(rd_valid && rd_data == 8'hE7, "R5 read byte waits for ready", rd_data, 8'hE7);
        chk(!req_ready, "R8 not ready while byte waits", req_ready, 0);
        req_op = 2'd0; req_byte = 8'hFF; req_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && nand_we_n, "R8 request blocked while byte waits", {busy, nand_we_n}, 2'b01);
        chk(rd_valid && rd_data == 8'hE7, "R5 read byte held under back-pressure", rd_data, 8'hE7);
        req_valid = 1'b0;
        @(negedge clk);
        rd_ready = 1'b1;
        @(negedge clk);
        chk(!rd_valid && req_ready, "R8 ready after byte taken", {rd_valid, req_ready}, 2'b01);

        // R3: same address word with four and five bytes differs only in the top byte.
        do_req(2'd1, 1'b0, 1'b1, 40'h12_3456_789A);
        chk(we_pulses == 5 && lb[4] == 8'h12, "R3 fifth byte sent", {we_pulses[7:0], lb[4]}, 16'h0512);
        do_req(2'd1, 1'b0, 1'b0, 40'h12_3456_789A);
        chk(we_pulses == 4 && lb[3] == 8'h34, "R3 four bytes, top byte dropped", {we_pulses[7:0], lb[3]}, 16'h0434);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule